// File: doc/BRIEF.md
# Event-Driven DMA Channel Controller

This block holds a bank of transfer parameter records and turns synchronisation events into transfer requests for a downstream copy engine. The low-numbered records belong to channels, one per event input. The remaining records can only be reached as link targets. Each event on a channel is latched as pending. When the controller serves it, it builds one request from the channel's live record, presents it on a valid/ready port, and, once the request is accepted, advances the record's addresses and counters.

Two synchronisation styles are supported. In array mode, one event moves a single array. In block mode, one event moves a whole block of arrays. When a record's frame count runs out, the job is complete. The live record is then replaced by its linked record, or it is zeroed. Completion, and optionally every intermediate request, can post a chained event to another channel. A single external event can therefore start a sequence of transfers.

Software fills the records through a simple write port. Each write sets one field of one record.

Top module: `dmacc_ctrl`

## Requirements
- R1: After reset, no request is valid, no done or chain pulse is raised, and every channel error flag is clear.
- R2: In block mode (option bit 0 = 1), each event produces a request that carries the live source, destination, ACNT and BCNT, plus the array strides. After acceptance, the frame strides are added to source and destination and CCNT drops by one.
- R3: In array mode (option bit 0 = 0), each request moves one array (request BCNT 1, request strides 0). Its addresses are base + b·array-stride + c·frame-stride, where b is the array index and c is the frame index. BCNT drops by one per event. When it would reach zero, CCNT drops by one and BCNT is refilled from the reload field.
- R4: The request that consumes the last count raises done_valid for one cycle, one cycle after acceptance, with done_ch set to that channel.
- R5: On completion, if option bit 1 is set, the live record becomes a copy of the record selected by option bits 15:8. Otherwise the live record is cleared to zero.
- R6: On completion with option bit 2 set, chain_valid pulses one cycle after acceptance with chain_ch = option bits 23:16. That channel then receives an event.
- R7: With option bit 3 set, every accepted request that is not the final one posts a chained event to channel option bits 23:16. A final request with only bit 3 set posts none.
- R8: An event served while the channel's record has a zero ACNT, BCNT or CCNT sets that channel's err_flag and issues no request. The flag stays set until any field of that channel's record is written.
- R9: Only one request is outstanding at a time. While req_valid is high and req_ready is low, the request fields hold steady.
- R10: Events are latched as pending bits. When several channels are pending, the lowest-numbered channel is served first, and events that arrive during a stall are not lost.
- R11: Write field codes are: 0 source, 1 destination, 2 ACNT, 3 BCNT, 4 BCNT reload, 5 CCNT, 6 source array stride, 7 destination array stride, 8 source frame stride, 9 destination frame stride, 10 option word. Strides are signed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt | input | NUM_CH | Per-channel synchronisation event pulses |
| wr_en | input | 1 | Record field write strobe |
| wr_idx | input | clog2(NUM_REC) | Record written |
| wr_fld | input | 4 | Field code (R11) |
| wr_data | input | 32 | Field value, right-aligned |
| req_valid | output | 1 | Transfer request valid |
| req_ready | input | 1 | Transfer engine accepts the request |
| req_ch | output | clog2(NUM_CH) | Channel that owns the request |
| req_src | output | AW | Source address |
| req_dst | output | AW | Destination address |
| req_acnt | output | CW | Bytes per array |
| req_bcnt | output | CW | Arrays in this request |
| req_sbidx | output | IW | Source stride between arrays |
| req_dbidx | output | IW | Destination stride between arrays |
| done_valid | output | 1 | Job completion pulse |
| done_ch | output | clog2(NUM_CH) | Completed channel |
| chain_valid | output | 1 | Chained event pulse |
| chain_ch | output | clog2(NUM_CH) | Channel receiving the chained event |
| err_flag | output | NUM_CH | Sticky per-channel null-record error |

## Verification
The bound checker watches four properties on every cycle. It checks that a stalled request holds its fields, that no request ever carries a zero ACNT or BCNT, that done and chain pulses only follow an accepted request, and that error flags fall only after a record write. The full address sequences can only be shown by the bench's scenarios. These include the array-mode walk across a frame boundary, the reload from a linked spare record, the order in which chained and prioritised channels are served, and the suppression of chaining on a final request that has only the intermediate option.

// File: rtl/dmacc_pkg.sv
package dmacc_pkg;
   parameter int AW = 16;   // address width
   parameter int CW = 8;    // count width
   parameter int IW = 16;   // signed stride width
   parameter int XW = 8;    // link / chain target field width

   typedef enum logic [3:0] {
      F_SRC = 4'd0, F_DST = 4'd1, F_ACNT = 4'd2, F_BCNT = 4'd3,
      F_BRLD = 4'd4, F_CCNT = 4'd5, F_SBIDX = 4'd6, F_DBIDX = 4'd7,
      F_SCIDX = 4'd8, F_DCIDX = 4'd9, F_OPT = 4'd10
   } fld_e;

   typedef struct packed {
      logic [AW-1:0] src;
      logic [AW-1:0] dst;
      logic [CW-1:0] acnt;
      logic [CW-1:0] bcnt;
      logic [CW-1:0] brld;
      logic [CW-1:0] ccnt;
      logic [IW-1:0] sbidx;
      logic [IW-1:0] dbidx;
      logic [IW-1:0] scidx;
      logic [IW-1:0] dcidx;
      logic          ab;
      logic          lnk_en;
      logic          tc_en;
      logic          itc_en;
      logic [XW-1:0] lnk;
      logic [XW-1:0] tc;
   } rec_t;
endpackage

// File: rtl/dmacc_rec_store.sv
module dmacc_rec_store
   import dmacc_pkg::*;
#(
   parameter int NUM_REC = 8,
   localparam int RIW = $clog2(NUM_REC)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en,
   input  logic [RIW-1:0] wr_idx,
   input  logic [3:0]     wr_fld,
   input  logic [31:0]    wr_data,
   input  logic           upd_en,
   input  logic [RIW-1:0] upd_idx,
   input  rec_t           upd_rec,
   output rec_t           recs [NUM_REC]
);

   for (genvar i = 0; i < NUM_REC; i++) begin : g_rec
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            recs[i] <= '0;
         end else if (upd_en && upd_idx == RIW'(i)) begin
            recs[i] <= upd_rec;
         end else if (wr_en && wr_idx == RIW'(i)) begin
            case (wr_fld)
               F_SRC:   recs[i].src   <= wr_data[AW-1:0];
               F_DST:   recs[i].dst   <= wr_data[AW-1:0];
               F_ACNT:  recs[i].acnt  <= wr_data[CW-1:0];
               F_BCNT:  recs[i].bcnt  <= wr_data[CW-1:0];
               F_BRLD:  recs[i].brld  <= wr_data[CW-1:0];
               F_CCNT:  recs[i].ccnt  <= wr_data[CW-1:0];
               F_SBIDX: recs[i].sbidx <= wr_data[IW-1:0];
               F_DBIDX: recs[i].dbidx <= wr_data[IW-1:0];
               F_SCIDX: recs[i].scidx <= wr_data[IW-1:0];
               F_DCIDX: recs[i].dcidx <= wr_data[IW-1:0];
               F_OPT: begin
                  recs[i].ab     <= wr_data[0];
                  recs[i].lnk_en <= wr_data[1];
                  recs[i].tc_en  <= wr_data[2];
                  recs[i].itc_en <= wr_data[3];
                  recs[i].lnk    <= wr_data[8 +: XW];
                  recs[i].tc     <= wr_data[16 +: XW];
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/dmacc_pick.sv
module dmacc_pick #(
   parameter int N = 4,
   localparam int IXW = $clog2(N)
) (
   input  logic [N-1:0]   pend,
   output logic           any,
   output logic [IXW-1:0] idx
);

   always_comb begin
      any = |pend;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (pend[i]) idx = IXW'(i);
      end
   end

endmodule

// File: rtl/dmacc_step.sv
module dmacc_step
   import dmacc_pkg::*;
#(
   parameter bit A_MODE_EN = 1'b1
) (
   input  rec_t          cur,
   input  logic [AW-1:0] soff,
   input  logic [AW-1:0] doff,
   output rec_t          nxt,
   output logic [AW-1:0] nsoff,
   output logic [AW-1:0] ndoff,
   output logic          last,
   output logic [AW-1:0] o_src,
   output logic [AW-1:0] o_dst,
   output logic [CW-1:0] o_bcnt,
   output logic [IW-1:0] o_sb,
   output logic [IW-1:0] o_db
);

   function automatic logic [AW-1:0] sx(input logic [IW-1:0] v);
      return AW'($signed(v));
   endfunction

   logic a_mode;
   if (A_MODE_EN) begin : g_amode
      assign a_mode = ~cur.ab;
   end else begin : g_abonly
      assign a_mode = 1'b0;
   end

   always_comb begin
      nxt   = cur;
      nsoff = soff;
      ndoff = doff;
      if (a_mode) begin
         o_src  = cur.src + soff;
         o_dst  = cur.dst + doff;
         o_bcnt = CW'(1);
         o_sb   = '0;
         o_db   = '0;
         if (cur.bcnt == CW'(1)) begin
            nxt.bcnt = cur.brld;
            nxt.ccnt = cur.ccnt - CW'(1);
            nxt.src  = cur.src + sx(cur.scidx);
            nxt.dst  = cur.dst + sx(cur.dcidx);
            nsoff    = '0;
            ndoff    = '0;
            last     = (cur.ccnt == CW'(1));
         end else begin
            nxt.bcnt = cur.bcnt - CW'(1);
            nsoff    = soff + sx(cur.sbidx);
            ndoff    = doff + sx(cur.dbidx);
            last     = 1'b0;
         end
      end else begin
         o_src    = cur.src;
         o_dst    = cur.dst;
         o_bcnt   = cur.bcnt;
         o_sb     = cur.sbidx;
         o_db     = cur.dbidx;
         nxt.src  = cur.src + sx(cur.scidx);
         nxt.dst  = cur.dst + sx(cur.dcidx);
         nxt.ccnt = cur.ccnt - CW'(1);
         last     = (cur.ccnt == CW'(1));
      end
   end

endmodule

// File: rtl/dmacc_ctrl.sv
module dmacc_ctrl
   import dmacc_pkg::*;
#(
   parameter int NUM_CH    = 4,
   parameter int NUM_REC   = 8,
   parameter bit A_MODE_EN = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_CH-1:0]          evt,
   input  logic                       wr_en,
   input  logic [$clog2(NUM_REC)-1:0] wr_idx,
   input  logic [3:0]                 wr_fld,
   input  logic [31:0]                wr_data,
   output logic                       req_valid,
   input  logic                       req_ready,
   output logic [$clog2(NUM_CH)-1:0]  req_ch,
   output logic [AW-1:0]              req_src,
   output logic [AW-1:0]              req_dst,
   output logic [CW-1:0]              req_acnt,
   output logic [CW-1:0]              req_bcnt,
   output logic [IW-1:0]              req_sbidx,
   output logic [IW-1:0]              req_dbidx,
   output logic                       done_valid,
   output logic [$clog2(NUM_CH)-1:0]  done_ch,
   output logic                       chain_valid,
   output logic [$clog2(NUM_CH)-1:0]  chain_ch,
   output logic [NUM_CH-1:0]          err_flag
);

   localparam int CHW = $clog2(NUM_CH);
   localparam int RIW = $clog2(NUM_REC);

   if (NUM_CH < 2 || (NUM_CH & (NUM_CH - 1)) != 0) begin : g_bad_ch
      $error("NUM_CH must be a power of two, at least 2");
   end
   if (NUM_REC < NUM_CH || (NUM_REC & (NUM_REC - 1)) != 0 || RIW > XW) begin : g_bad_rec
      $error("NUM_REC must be a power of two, at least NUM_CH, addressable by the link field");
   end
   if (AW > 32 || IW > 32 || CW > 32 || CHW > XW) begin : g_bad_w
      $error("field widths exceed the write port");
   end

   rec_t              recs [NUM_REC];
   logic [NUM_CH-1:0] pend_q;
   logic              busy_q;
   logic [CHW-1:0]    cur_q;
   logic [AW-1:0]     soff_q [NUM_CH];
   logic [AW-1:0]     doff_q [NUM_CH];

   logic              any;
   logic [CHW-1:0]    pidx;
   rec_t              live, cand, nxt, upd_rec;
   logic [AW-1:0]     nsoff, ndoff;
   logic              last, hs, cand_null, chain_fire;
   logic [CHW-1:0]    tgt;

   dmacc_rec_store #(.NUM_REC(NUM_REC)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_fld  (wr_fld),
      .wr_data (wr_data),
      .upd_en  (hs),
      .upd_idx (RIW'(cur_q)),
      .upd_rec (upd_rec),
      .recs    (recs)
   );

   dmacc_pick #(.N(NUM_CH)) u_pick (
      .pend (pend_q),
      .any  (any),
      .idx  (pidx)
   );

   dmacc_step #(.A_MODE_EN(A_MODE_EN)) u_step (
      .cur    (live),
      .soff   (soff_q[cur_q]),
      .doff   (doff_q[cur_q]),
      .nxt    (nxt),
      .nsoff  (nsoff),
      .ndoff  (ndoff),
      .last   (last),
      .o_src  (req_src),
      .o_dst  (req_dst),
      .o_bcnt (req_bcnt),
      .o_sb   (req_sbidx),
      .o_db   (req_dbidx)
   );

   assign live       = recs[RIW'(cur_q)];
   assign cand       = recs[RIW'(pidx)];
   assign cand_null  = (cand.acnt == '0) || (cand.bcnt == '0) || (cand.ccnt == '0);
   assign hs         = busy_q && req_ready;
   assign tgt        = live.tc[CHW-1:0];
   assign chain_fire = hs && (last ? live.tc_en : live.itc_en);
   assign upd_rec    = !last ? nxt : (live.lnk_en ? recs[live.lnk[RIW-1:0]] : '0);

   assign req_valid  = busy_q;
   assign req_ch     = cur_q;
   assign req_acnt   = live.acnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q      <= '0;
         busy_q      <= 1'b0;
         cur_q       <= '0;
         err_flag    <= '0;
         done_valid  <= 1'b0;
         done_ch     <= '0;
         chain_valid <= 1'b0;
         chain_ch    <= '0;
         for (int i = 0; i < NUM_CH; i++) begin
            soff_q[i] <= '0;
            doff_q[i] <= '0;
         end
      end else begin
         pend_q <= (pend_q & ~((!busy_q && any) ? (NUM_CH'(1) << pidx) : '0))
                   | evt | (chain_fire ? (NUM_CH'(1) << tgt) : '0);

         for (int i = 0; i < NUM_CH; i++) begin
            if (wr_en && wr_idx == RIW'(i)) err_flag[i] <= 1'b0;
         end

         if (!busy_q && any) begin
            if (cand_null) begin
               err_flag[pidx] <= 1'b1;
            end else begin
               busy_q <= 1'b1;
               cur_q  <= pidx;
            end
         end else if (hs) begin
            busy_q <= 1'b0;
         end

         if (hs) begin
            soff_q[cur_q] <= last ? '0 : nsoff;
            doff_q[cur_q] <= last ? '0 : ndoff;
         end

         done_valid  <= hs && last;
         done_ch     <= cur_q;
         chain_valid <= chain_fire;
         chain_ch    <= tgt;
      end
   end

endmodule

// File: rtl/dmacc_chk.sv
module dmacc_chk
   import dmacc_pkg::*;
#(
   parameter int NUM_CH  = 4,
   parameter int NUM_REC = 8
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       wr_en,
   input logic                       req_valid,
   input logic                       req_ready,
   input logic [$clog2(NUM_CH)-1:0]  req_ch,
   input logic [AW-1:0]              req_src,
   input logic [AW-1:0]              req_dst,
   input logic [CW-1:0]              req_acnt,
   input logic [CW-1:0]              req_bcnt,
   input logic                       done_valid,
   input logic                       chain_valid,
   input logic [NUM_CH-1:0]          err_flag
);

   // R9: a stalled request keeps every field
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_ready |=> req_valid && $stable(req_ch) && $stable(req_src)
      && $stable(req_dst) && $stable(req_acnt) && $stable(req_bcnt));

   // R8: a null record never reaches the engine
   p_nonnull_r8: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_acnt != '0) && (req_bcnt != '0));

   // R4: completion only follows an accepted request
   p_done_hs_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |-> $past(req_valid && req_ready));

   // R6: chaining only follows an accepted request
   p_chain_hs_r6: assert property (@(posedge clk) disable iff (!rst_n)
      chain_valid |-> $past(req_valid && req_ready));

   // R8: error flags fall only after a record write
   p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_en) |-> ((err_flag & $past(err_flag)) == $past(err_flag)));

endmodule

bind dmacc_ctrl dmacc_chk #(.NUM_CH(NUM_CH), .NUM_REC(NUM_REC)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .req_valid   (req_valid),
   .req_ready   (req_ready),
   .req_ch      (req_ch),
   .req_src     (req_src),
   .req_dst     (req_dst),
   .req_acnt    (req_acnt),
   .req_bcnt    (req_bcnt),
   .done_valid  (done_valid),
   .chain_valid (chain_valid),
   .err_flag    (err_flag)
);

// File: tb/dmacc_ctrl_tb.sv
`timescale 1ns/1ps
module dmacc_ctrl_tb;
   localparam int NCH = 4;
   localparam int NREC = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NCH-1:0] evt = '0;
   logic wr_en = 1'b0;
   logic [2:0] wr_idx = '0;
   logic [3:0] wr_fld = '0;
   logic [31:0] wr_data = '0;
   logic req_valid, req_ready;
   logic [1:0] req_ch, done_ch, chain_ch;
   logic [15:0] req_src, req_dst, req_sbidx, req_dbidx;
   logic [7:0] req_acnt, req_bcnt;
   logic done_valid, chain_valid;
   logic [NCH-1:0] err_flag;

   int checks = 0;
   int errors = 0;

   typedef struct packed {
      logic [1:0]  ch;
      logic [15:0] src, dst;
      logic [7:0]  acnt, bcnt;
      logic [15:0] sb, db;
   } exp_t;

   exp_t  rq[$];
   string rtag[$];
   int    dq[$];
   int    cq[$];

   always #4 clk = ~clk;

   dmacc_ctrl #(.NUM_CH(NCH), .NUM_REC(NREC)) u_dut (.*);

   task automatic check(input string tag, input bit ok, input string what,
                        input longint act, input longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
      end
   endtask

   task automatic exp_req(input string tag, input int ch, input int src, input int dst,
                          input int acnt, input int bcnt, input int sb, input int db);
      exp_t e;
      e.ch = 2'(ch); e.src = 16'(src); e.dst = 16'(dst);
      e.acnt = 8'(acnt); e.bcnt = 8'(bcnt); e.sb = 16'(sb); e.db = 16'(db);
      rq.push_back(e);
      rtag.push_back(tag);
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (req_valid && req_ready) begin
            exp_t a;
            a = {req_ch, req_src, req_dst, req_acnt, req_bcnt, req_sbidx, req_dbidx};
            if (rq.size() == 0) begin
               check("R8", 1'b0, "unexpected request", longint'(a), 0);
            end else begin
               exp_t e;
               string t;
               e = rq.pop_front();
               t = rtag.pop_front();
               check(t, a == e, "request", longint'(a), longint'(e));
            end
         end
         if (done_valid) begin
            if (dq.size() == 0) check("R4", 1'b0, "unexpected done", done_ch, 0);
            else begin
               int d;
               d = dq.pop_front();
               check("R4", int'(done_ch) == d, "done channel", done_ch, d);
            end
         end
         if (chain_valid) begin
            if (cq.size() == 0) check("R7", 1'b0, "unexpected chain", chain_ch, 0);
            else begin
               int c;
               c = cq.pop_front();
               check("R6", int'(chain_ch) == c, "chain channel", chain_ch, c);
            end
         end
      end
   end

   task automatic wr(input int idx, input int f, input int d);
      wr_en = 1'b1; wr_idx = 3'(idx); wr_fld = 4'(f); wr_data = 32'(d);
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   // R11 field codes 0..10
   task automatic cfg(input int r, input int src, input int dst, input int acnt,
                      input int bcnt, input int brld, input int ccnt, input int sb,
                      input int db, input int sc, input int dc, input int opt);
      wr(r, 0, src);  wr(r, 1, dst);  wr(r, 2, acnt); wr(r, 3, bcnt);
      wr(r, 4, brld); wr(r, 5, ccnt); wr(r, 6, sb);   wr(r, 7, db);
      wr(r, 8, sc);   wr(r, 9, dc);   wr(r, 10, opt);
   endtask

   task automatic fire(input int mask);
      evt = NCH'(mask);
      @(posedge clk); #1;
      evt = '0;
   endtask

   task automatic settle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      req_ready = 1'b1;
      settle(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1", !req_valid && !done_valid && !chain_valid, "idle after reset",
            {req_valid, done_valid, chain_valid}, 0);
      check("R1", err_flag == '0, "error flags", err_flag, 0);
      @(posedge clk); #1;

      // R2 block mode on channel 0
      cfg(0, 'h100, 'h200, 4, 1, 0, 3, 0, 0, 4, 0, 'h1);
      exp_req("R2", 0, 'h100, 'h200, 4, 1, 0, 0);
      exp_req("R2", 0, 'h104, 'h200, 4, 1, 0, 0);
      exp_req("R2", 0, 'h108, 'h200, 4, 1, 0, 0);
      dq.push_back(0);
      for (int k = 0; k < 3; k++) begin fire(1); settle(4); end
      // R5: no link, so the record is cleared; R8: next event errors
      fire(1); settle(4);
      check("R8", err_flag[0] == 1'b1, "error on cleared channel 0", err_flag, 1);

      // R3 array mode on channel 1
      cfg(1, 'h1000, 'h2000, 2, 2, 3, 2, 2, 'h10, 'h40, 'h100, 'h0);
      exp_req("R3", 1, 'h1000, 'h2000, 2, 1, 0, 0);
      exp_req("R3", 1, 'h1002, 'h2010, 2, 1, 0, 0);
      exp_req("R3", 1, 'h1040, 'h2100, 2, 1, 0, 0);
      exp_req("R3", 1, 'h1042, 'h2110, 2, 1, 0, 0);
      exp_req("R3", 1, 'h1044, 'h2120, 2, 1, 0, 0);
      dq.push_back(1);
      for (int k = 0; k < 5; k++) begin fire(2); settle(4); end

      // R5 link to spare record 5, R6 chain to channel 3
      cfg(5, 'h500, 'h600, 1, 1, 0, 1, 0, 0, 0, 0, 'h1);
      cfg(3, 'h700, 'h800, 4, 1, 0, 2, 0, 0, 4, 4, 'h1);
      cfg(2, 'h300, 'h400, 8, 2, 0, 1, 8, 8, 0, 0, 'h0003_0507);
      exp_req("R6", 2, 'h300, 'h400, 8, 2, 8, 8);
      dq.push_back(2);
      cq.push_back(3);
      exp_req("R6", 3, 'h700, 'h800, 4, 1, 0, 0);
      fire(4); settle(8);
      exp_req("R5", 2, 'h500, 'h600, 1, 1, 0, 0);
      dq.push_back(2);
      fire(4); settle(4);
      fire(4); settle(4);
      check("R5", err_flag[2] == 1'b1, "linked record exhausted then cleared", err_flag, 4'h5);

      // R7 intermediate chaining from channel 0 to channel 3
      cfg(0, 'h10, 'h20, 4, 1, 0, 2, 0, 0, 4, 0, 'h0003_0009);
      check("R8", err_flag[0] == 1'b0, "error cleared by record write", err_flag[0], 0);
      exp_req("R7", 0, 'h10, 'h20, 4, 1, 0, 0);
      cq.push_back(3);
      exp_req("R7", 3, 'h704, 'h804, 4, 1, 0, 0);
      dq.push_back(3);
      fire(1); settle(8);
      exp_req("R7", 0, 'h14, 'h20, 4, 1, 0, 0);
      dq.push_back(0);
      fire(1); settle(6);

      // R9 / R10 stall with two simultaneous events
      cfg(0, 'hA00, 'hB00, 4, 1, 0, 1, 0, 0, 0, 0, 'h1);
      cfg(1, 'hC00, 'hD00, 4, 1, 0, 1, 0, 0, 0, 0, 'h1);
      req_ready = 1'b0;
      fire(3); settle(6);
      @(negedge clk);
      check("R10", req_valid && req_ch == 2'd0, "lowest channel first", {req_valid, req_ch}, 3'b100);
      check("R9", req_src == 16'hA00, "held source under stall", req_src, 'hA00);
      exp_req("R10", 0, 'hA00, 'hB00, 4, 1, 0, 0);
      exp_req("R10", 1, 'hC00, 'hD00, 4, 1, 0, 0);
      dq.push_back(0);
      dq.push_back(1);
      @(posedge clk); #1;
      req_ready = 1'b1;
      settle(12);

      check("R4", rq.size() == 0, "outstanding expected requests", rq.size(), 0);
      check("R4", dq.size() == 0, "outstanding expected completions", dq.size(), 0);
      check("R6", cq.size() == 0, "outstanding expected chains", cq.size(), 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule